// File: doc/BRIEF.md
# Variation-Aware Thread-to-Core Mapper

Within one chip, cores built to the same design differ in the highest clock they can sustain and in how much they leak. This block takes one figure of merit per core and one per thread, ranks both lists, and pairs them rank by rank. Each mapped thread gets a core of its own. It reports a core index for every thread, along with a mask of the cores that received work. Cores left idle in the mask can be gated off.

Two ranking policies are supported. In performance mode, the fastest cores take the threads with the highest IPC. In power mode, the least leaky cores take the threads with the highest dynamic power, which spreads heat evenly across the die. A pass begins on a start pulse. The block latches all keys at that moment and fills one rank per clock. It then raises a single-cycle done, and its outputs hold until the next accepted start.

Top module: `thread_core_mapper`

## Requirements
- R1: With modeSel=0 (performance), cores are taken in order of descending coreKeys value (maximum frequency). The k-th ranked thread lands on the k-th ranked core.
- R2: With modeSel=0, threads are ranked by descending threadKeys value (IPC).
- R3: With modeSel=1 (power), cores are ranked by ascending coreKeys value (static power) and threads by descending threadKeys value (dynamic power). The hungriest thread therefore sits on the least leaky core.
- R4: Equal keys are ordered by lower index first, for cores and for threads alike.
- R5: Thread t is mapped only when t < the effective thread count. Mapped threads receive pairwise distinct core indices. Every other thread reads back the all-ones code on its field of threadCore, which occupies bits [t*IDX_W +: IDX_W].
- R6: Bit c of coreActive is 1 exactly when some thread was mapped to core c. A pass with a count of 0 leaves every bit at 0.
- R7: Let n be the effective count. done is high for exactly one cycle, in the (n+1)-th cycle after the cycle in which start was sampled high.
- R8: The block captures keys, mode and count only when it accepts start. A start that arrives while ranks are still being filled is ignored. Outside a pass, threadCore and coreActive hold their values.
- R9: A threadCount above NUM_CORES is treated as NUM_CORES.
- R10: After reset, done is 0, coreActive is all zeros and every threadCore field holds the all-ones code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a mapping pass when the block is not filling ranks |
| modeSel | input | 1 | 0 = performance ranking, 1 = power ranking |
| threadCount | input | CNT_W | Number of threads to place (clamped to NUM_CORES) |
| coreKeys | input | NUM_CORES*KEY_W | Per-core key, core c at bits [c*KEY_W +: KEY_W] |
| threadKeys | input | NUM_CORES*KEY_W | Per-thread key, thread t at bits [t*KEY_W +: KEY_W] |
| done | output | 1 | One-cycle pulse when the mapping is valid |
| threadCore | output | NUM_CORES*IDX_W | Core index per thread, all-ones when unmapped |
| coreActive | output | NUM_CORES | Cores that received a thread |

## Verification
The ordering checks assume that keys, mode and count seen by the ranking logic come only from the snapshot taken at start, so input changes in mid-pass cannot break the monotone order of selected keys. The stimulus changes keys and mode in the middle of a pass and raises start while ranks are still being filled. This exercises that assumption instead of avoiding it. The stimulus also uses a narrow key range so that ties occur, counts of 0, full and above full, and a start in the same cycle as done.

// File: rtl/tcm_pkg.sv
package tcm_pkg;

  typedef enum logic {
    MODE_PERF  = 1'b0,
    MODE_POWER = 1'b1
  } rankMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // snapshot inputs, clear previous mapping
    logic pick;   // place one rank
  } mapStrobe_t;

endpackage

// File: rtl/tcm_ctrl.sv
module tcm_ctrl
  import tcm_pkg::*;
#(
  parameter int NUM_CORES = 20,
  parameter int CNT_W     = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] threadCount,
  output mapStrobe_t       strobe,
  output logic             done
);

  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(NUM_CORES);

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_PICK = 2'd1,
    S_DONE = 2'd2
  } ctrlState_e;

  ctrlState_e       state;
  logic [CNT_W-1:0] ranksLeft;
  logic [CNT_W-1:0] reqCount;
  logic             accept;

  assign reqCount = (threadCount > MAX_CNT) ? MAX_CNT : threadCount;
  assign accept   = start && (state != S_PICK);

  always_comb begin
    strobe      = '0;
    strobe.load = accept;
    strobe.pick = (state == S_PICK);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      ranksLeft <= '0;
    end else if (accept) begin
      ranksLeft <= reqCount;
      state     <= (reqCount == '0) ? S_DONE : S_PICK;
    end else begin
      case (state)
        S_PICK: begin
          ranksLeft <= ranksLeft - 1'b1;
          if (ranksLeft == CNT_W'(1)) state <= S_DONE;
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign done = (state == S_DONE);

  // R7
  pick_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_PICK) |-> (ranksLeft != '0 && ranksLeft <= MAX_CNT));

  // R8
  no_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_PICK && start && ranksLeft > CNT_W'(1)) |=> (state == S_PICK && ranksLeft == $past(ranksLeft) - 1'b1));

endmodule

// File: rtl/tcm_datapath.sv
module tcm_datapath
  import tcm_pkg::*;
#(
  parameter int NUM_CORES = 20,
  parameter int KEY_W     = 16,
  parameter int IDX_W     = 5,
  parameter int CNT_W     = 5
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  mapStrobe_t                 strobe,
  input  logic                       modeSel,
  input  logic [CNT_W-1:0]           threadCount,
  input  logic [NUM_CORES*KEY_W-1:0] coreKeys,
  input  logic [NUM_CORES*KEY_W-1:0] threadKeys,
  output logic [NUM_CORES*IDX_W-1:0] threadCore,
  output logic [NUM_CORES-1:0]       coreActive
);

  localparam logic [CNT_W-1:0] MAX_CNT  = CNT_W'(NUM_CORES);
  localparam logic [IDX_W-1:0] UNMAPPED = '1;

  logic [KEY_W-1:0] coreKeyIn [NUM_CORES];
  logic [KEY_W-1:0] thrKeyIn  [NUM_CORES];
  logic [KEY_W-1:0] coreKeyQ  [NUM_CORES];
  logic [KEY_W-1:0] thrKeyQ   [NUM_CORES];
  logic [IDX_W-1:0] assignQ   [NUM_CORES];
  logic [NUM_CORES-1:0] coreUsed;
  logic [NUM_CORES-1:0] thrUsed;
  rankMode_e        modeQ;
  logic [CNT_W-1:0] loadCount;

  logic [IDX_W-1:0] selCore, selThr;
  logic [KEY_W-1:0] selCoreKey, selThrKey;
  logic             coreFound, thrFound;

  assign loadCount = (threadCount > MAX_CNT) ? MAX_CNT : threadCount;

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_lane
    assign coreKeyIn[g]                  = coreKeys[g*KEY_W +: KEY_W];
    assign thrKeyIn[g]                   = threadKeys[g*KEY_W +: KEY_W];
    assign threadCore[g*IDX_W +: IDX_W]  = assignQ[g];
  end

  assign coreActive = coreUsed;

  // best free core: strict compare keeps the lowest index on ties
  always_comb begin
    selCore    = '0;
    selCoreKey = '0;
    coreFound  = 1'b0;
    for (int i = 0; i < NUM_CORES; i++) begin
      if (!coreUsed[i]) begin
        if (!coreFound ||
            ((modeQ == MODE_PERF)  && (coreKeyQ[i] > selCoreKey)) ||
            ((modeQ == MODE_POWER) && (coreKeyQ[i] < selCoreKey))) begin
          coreFound  = 1'b1;
          selCore    = IDX_W'(i);
          selCoreKey = coreKeyQ[i];
        end
      end
    end
  end

  // best free thread: highest key in both modes
  always_comb begin
    selThr    = '0;
    selThrKey = '0;
    thrFound  = 1'b0;
    for (int i = 0; i < NUM_CORES; i++) begin
      if (!thrUsed[i]) begin
        if (!thrFound || (thrKeyQ[i] > selThrKey)) begin
          thrFound  = 1'b1;
          selThr    = IDX_W'(i);
          selThrKey = thrKeyQ[i];
        end
      end
    end
  end

  // key snapshot, no reset needed
  always_ff @(posedge clk) begin
    if (strobe.load) begin
      for (int i = 0; i < NUM_CORES; i++) begin
        coreKeyQ[i] <= coreKeyIn[i];
        thrKeyQ[i]  <= thrKeyIn[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ    <= MODE_PERF;
      coreUsed <= '0;
      thrUsed  <= '1;
      for (int i = 0; i < NUM_CORES; i++) assignQ[i] <= UNMAPPED;
    end else if (strobe.load) begin
      modeQ    <= rankMode_e'(modeSel);
      coreUsed <= '0;
      for (int i = 0; i < NUM_CORES; i++) begin
        thrUsed[i] <= (CNT_W'(i) >= loadCount);
        assignQ[i] <= UNMAPPED;
      end
    end else if (strobe.pick && coreFound && thrFound) begin
      assignQ[selThr]   <= selCore;
      coreUsed[selCore] <= 1'b1;
      thrUsed[selThr]   <= 1'b1;
    end
  end

  // R5
  no_reuse_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pick |-> (coreFound && thrFound));

  // R1
  perf_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pick && $past(strobe.pick) && modeQ == MODE_PERF) |-> (selCoreKey <= $past(selCoreKey)));

  // R3
  power_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pick && $past(strobe.pick) && modeQ == MODE_POWER) |-> (selCoreKey >= $past(selCoreKey)));

  // R2
  thread_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pick && $past(strobe.pick)) |-> (selThrKey <= $past(selThrKey)));

  // R6
  active_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pick |=> ($countones(coreActive) == $past($countones(coreActive)) + 1));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.load || strobe.pick) |=> ($stable(coreActive) && $stable(threadCore)));

endmodule

// File: rtl/thread_core_mapper.sv
module thread_core_mapper
  import tcm_pkg::*;
#(
  parameter  int NUM_CORES = 20,
  parameter  int KEY_W     = 16,
  localparam int IDX_W     = $clog2(NUM_CORES + 1),
  localparam int CNT_W     = $clog2(NUM_CORES + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       start,
  input  logic                       modeSel,
  input  logic [CNT_W-1:0]           threadCount,
  input  logic [NUM_CORES*KEY_W-1:0] coreKeys,
  input  logic [NUM_CORES*KEY_W-1:0] threadKeys,
  output logic                       done,
  output logic [NUM_CORES*IDX_W-1:0] threadCore,
  output logic [NUM_CORES-1:0]       coreActive
);

  mapStrobe_t strobe;

  tcm_ctrl #(
    .NUM_CORES (NUM_CORES),
    .CNT_W     (CNT_W)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .threadCount (threadCount),
    .strobe      (strobe),
    .done        (done)
  );

  tcm_datapath #(
    .NUM_CORES (NUM_CORES),
    .KEY_W     (KEY_W),
    .IDX_W     (IDX_W),
    .CNT_W     (CNT_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .modeSel     (modeSel),
    .threadCount (threadCount),
    .coreKeys    (coreKeys),
    .threadKeys  (threadKeys),
    .threadCore  (threadCore),
    .coreActive  (coreActive)
  );

  // R10
  reset_idle_chk: assert property (@(posedge clk)
    !rstN |=> (!done && coreActive == '0));

endmodule

// File: tb/sim_thread_core_mapper.sv
module sim_thread_core_mapper;

  localparam int NC    = 20;
  localparam int KW    = 16;
  localparam int IW    = $clog2(NC + 1);
  localparam int CW    = $clog2(NC + 1);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic              modeSel = 1'b0;
  logic [CW-1:0]     threadCount = '0;
  logic [NC*KW-1:0]  coreKeys = '0;
  logic [NC*KW-1:0]  threadKeys = '0;
  logic              done;
  logic [NC*IW-1:0]  threadCore;
  logic [NC-1:0]     coreActive;

  int compared = 0;
  int mismatched = 0;
  string curTag = "R10";

  thread_core_mapper #(.NUM_CORES(NC), .KEY_W(KW)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .modeSel(modeSel),
    .threadCount(threadCount), .coreKeys(coreKeys), .threadKeys(threadKeys),
    .done(done), .threadCore(threadCore), .coreActive(coreActive)
  );

  always #2.5 clk = ~clk;

  // ---------------- behavioural reference ----------------
  bit              mBusy, mDone;
  int              mRemain;
  logic [NC*IW-1:0] mCore, pCore;
  logic [NC-1:0]   mActive, pActive;
  int              pCount;

  task automatic computeRef();
    bit cu[NC];
    bit tu[NC];
    int n, bc, bt;
    logic [KW-1:0] ck, tk;
    n = (int'(threadCount) > NC) ? NC : int'(threadCount);
    pCount  = n;
    pCore   = '1;
    pActive = '0;
    for (int i = 0; i < NC; i++) begin cu[i] = 0; tu[i] = 0; end
    for (int r = 0; r < n; r++) begin
      bc = -1; bt = -1;
      for (int c = 0; c < NC; c++) begin
        ck = coreKeys[c*KW +: KW];
        if (!cu[c]) begin
          if (bc < 0) bc = c;
          else if (!modeSel && ck > coreKeys[bc*KW +: KW]) bc = c;
          else if (modeSel && ck < coreKeys[bc*KW +: KW]) bc = c;
        end
      end
      for (int t = 0; t < n; t++) begin
        tk = threadKeys[t*KW +: KW];
        if (!tu[t]) begin
          if (bt < 0 || tk > threadKeys[bt*KW +: KW]) bt = t;
        end
      end
      cu[bc] = 1; tu[bt] = 1;
      pCore[bt*IW +: IW] = IW'(bc);
      pActive[bc] = 1'b1;
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mDone = 0; mRemain = 0;
      mCore = '1; mActive = '0;
    end else begin
      mDone = 0;
      if (mBusy) begin
        mRemain--;
        if (mRemain == 0) begin
          mBusy = 0; mDone = 1; mCore = pCore; mActive = pActive;
        end
      end else if (start) begin
        computeRef();
        if (pCount == 0) begin
          mDone = 1; mCore = pCore; mActive = pActive;
        end else begin
          mBusy = 1; mRemain = pCount;
        end
      end
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      compared++;
      if (done !== mDone) begin
        mismatched++;
        $display("FAIL R7 done: actual %0b expected %0b at %0t", done, mDone, $time);
      end
      if (!mBusy) begin
        compared++;
        if (threadCore !== mCore) begin
          mismatched++;
          $display("FAIL %s threadCore: actual %h expected %h", curTag, threadCore, mCore);
        end
        compared++;
        if (coreActive !== mActive) begin
          mismatched++;
          $display("FAIL %s coreActive: actual %b expected %b", curTag, coreActive, mActive);
        end
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic fillKeys(input int range);
    for (int i = 0; i < NC; i++) begin
      coreKeys[i*KW +: KW]   = KW'($urandom_range(range));
      threadKeys[i*KW +: KW] = KW'($urandom_range(range));
    end
  endtask

  task automatic pulseStart(input logic mode, input int n);
    @(negedge clk);
    modeSel     = mode;
    threadCount = CW'(n);
    start       = 1'b1;
    @(negedge clk);
    start       = 1'b0;
  endtask

  task automatic waitIdle();
    while (mBusy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    compared++;
    if (done !== 1'b0 || coreActive !== '0 || threadCore !== '1) begin
      mismatched++;
      $display("FAIL R10 reset: actual done=%0b act=%b core=%h expected 0/0/all-ones",
               done, coreActive, threadCore);
    end
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R2 R5: performance, partial load, wide keys
    curTag = "R1 R2 R5 R6";
    fillKeys(65535);
    pulseStart(1'b0, 5); waitIdle();

    // R1 R6: performance, all cores busy
    curTag = "R1 R2 R6";
    fillKeys(65535);
    pulseStart(1'b0, NC); waitIdle();

    // R3: power ranking
    curTag = "R3 R5 R6";
    fillKeys(65535);
    pulseStart(1'b1, 7); waitIdle();
    fillKeys(65535);
    pulseStart(1'b1, NC); waitIdle();

    // R4: ties in both modes
    curTag = "R4";
    coreKeys = '0; threadKeys = '0;
    pulseStart(1'b0, 9); waitIdle();
    pulseStart(1'b1, 9); waitIdle();
    fillKeys(3);
    pulseStart(1'b0, 14); waitIdle();
    fillKeys(3);
    pulseStart(1'b1, 14); waitIdle();

    // R6 R7: empty pass clears the previous mapping
    curTag = "R6 R7";
    pulseStart(1'b0, 0); waitIdle();

    // R9: count above the pool is clamped
    curTag = "R9";
    fillKeys(65535);
    pulseStart(1'b1, 27); waitIdle();

    // R8: start and key changes during a pass are ignored
    curTag = "R8";
    fillKeys(65535);
    pulseStart(1'b0, 12);
    repeat (3) @(negedge clk);
    fillKeys(65535);
    modeSel = 1'b1; threadCount = CW'(2); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    fillKeys(65535);
    waitIdle();
    repeat (10) @(negedge clk);

    // R7 R8: start accepted in the done cycle
    curTag = "R7 R8";
    fillKeys(255);
    pulseStart(1'b0, 3);
    while (!done) @(negedge clk);
    fillKeys(255);
    modeSel = 1'b1; threadCount = CW'(4); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitIdle();

    // random sweep
    for (int k = 0; k < 30; k++) begin
      curTag = ((k % 2) == 0) ? "R1 R2 R4" : "R3 R4";
      fillKeys((k % 3 == 0) ? 7 : 65535);
      pulseStart(logic'(k % 2), $urandom_range(NC + 5));
      waitIdle();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule